// File: doc/BRIEF.md
# ECC operation status tracker

This block tracks one ECC operation at a time on behalf of a NAND-style flash controller and decides how that operation ended. To start an operation, software gives a start address, the number of data bytes it intends to supply, and a mode bit. The mode bit says whether the controller jumps across the page to store the ECC code bytes. While the operation runs, the block counts the data beats that actually arrive and holds a busy flag high. When software marks the end of the data, the block drops busy. In that same clock edge it publishes a 2-bit completion code.

The block covers three kinds of software misuse:

- a start address that is badly placed,
- a data amount that differs from the announced length,
- a partial page in the mode that does not jump.

The completion code is always produced from the operation that has just ended. A later good operation therefore never shows an earlier abort code, not even for one cycle. An aborted operation is never reported as a pass. The ECC arithmetic, the flash bus and the storage of code bytes are outside this block.

Top module: `ecc_op_tracker`

## Requirements
- R1: After reset, `busy_o` is 0 and `last_status_o` is 2'b00.
- R2: A start request while idle, at an address that is a multiple of `ALIGN_BYTES` (512) and below `ADDR_LIMIT`, sets `busy_o` to 1 on the next cycle.
- R3: A start request while idle, at an address that is not a multiple of `ALIGN_BYTES` or is at or above `ADDR_LIMIT`, leaves `busy_o` at 0 and sets `last_status_o` to 2'b01 on the next cycle. Data beats and end pulses that follow while idle change neither output.
- R4: When an operation ends with `skip_mode_i` captured as 0 and fewer than `PAGE_BYTES` (2048) bytes received, the code is 2'b11. This code takes priority over the length mismatch code.
- R5: Otherwise, when an operation ends with a received byte count different from the requested length, the code is 2'b10.
- R6: Otherwise, the operation completes with code 2'b00.
- R7: The result is visible in the very first cycle that `busy_o` is low again. After an earlier abort, a good operation reads 2'b00 in that cycle.
- R8: A start request while `busy_o` is 1 is ignored. The running operation keeps its length, its mode and its byte count.
- R9: `last_status_o` holds its value while an operation runs. It also holds its value while idle when no start request arrives.
- R10: A data beat presented in the same cycle as the end pulse is counted. Each beat carries `BEAT_BYTES` (4) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin an operation |
| start_addr_i | input | ADDR_W | Start address of the operation, in bytes |
| start_len_i | input | LEN_W | Number of data bytes software will supply |
| skip_mode_i | input | 1 | 1: controller jumps across the page for codes; 0: a full page is required |
| beat_i | input | 1 | One data beat of BEAT_BYTES bytes supplied this cycle |
| end_i | input | 1 | Software marks the end of the data |
| busy_o | output | 1 | Operation in progress |
| last_status_o | output | 2 | Completion code of the latest operation (00 pass, 01 address, 10 length, 11 partial page) |

## Verification
The bench runs an abort immediately followed by a good operation. It samples the code in the first idle cycle: a design that updates the code one cycle late would show the stale 10 there.

It also ends an operation in the non-jumping mode with a short page whose length does not match either. A design that orders the checks wrongly reports 10 instead of 11.

A beat arriving together with the end pulse shows whether the last beat is dropped, which would turn a pass into a length fault.

A start request issued in mid-operation with a different length and mode shows whether the running operation gets restarted. Beats and end pulses sent after a rejected address show whether idle-state input leaks into the code.

// File: rtl/ecc_trk_pkg.sv
package ecc_trk_pkg;

    typedef enum logic [1:0] {
        ST_PASS        = 2'b00,
        ST_ADDR_FAULT  = 2'b01,
        ST_COUNT_FAULT = 2'b10,
        ST_PAGE_FAULT  = 2'b11
    } ecc_code_e;

endpackage

// File: rtl/ecc_addr_check.sv
module ecc_addr_check #(
    parameter int          ADDR_W      = 32,
    parameter int          ALIGN_BYTES = 512,
    parameter int unsigned ADDR_LIMIT  = 32'h0100_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(ADDR_LIMIT);

    logic aligned;
    logic in_range;

    always_comb begin
        aligned  = (addr_i[ALIGN_LSB-1:0] == '0);
        in_range = (addr_i < LIMIT);
        ok_o     = aligned && in_range;
    end
endmodule

// File: rtl/ecc_outcome_classify.sv
module ecc_outcome_classify
    import ecc_trk_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 2048
) (
    input  logic             no_skip_i,
    input  logic [LEN_W:0]   got_bytes_i,
    input  logic [LEN_W-1:0] want_bytes_i,
    output ecc_code_e        code_o
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] PAGE = CNT_W'(PAGE_BYTES);

    logic short_page;
    logic mismatch;

    always_comb begin
        short_page = no_skip_i && (got_bytes_i < PAGE);
        mismatch   = (got_bytes_i != {1'b0, want_bytes_i});
        if (short_page) begin
            code_o = ST_PAGE_FAULT;
        end else if (mismatch) begin
            code_o = ST_COUNT_FAULT;
        end else begin
            code_o = ST_PASS;
        end
    end
endmodule

// File: rtl/ecc_op_tracker.sv
module ecc_op_tracker
    import ecc_trk_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          LEN_W       = 16,
    parameter int          PAGE_BYTES  = 2048,
    parameter int          ALIGN_BYTES = 512,
    parameter int          BEAT_BYTES  = 4,
    parameter int unsigned ADDR_LIMIT  = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              skip_mode_i,
    input  logic              beat_i,
    input  logic              end_i,
    output logic              busy_o,
    output logic [1:0]        last_status_o
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W:0] STEP = (CNT_W + 1)'(BEAT_BYTES);

    typedef struct packed {
        logic             busy;
        logic             skip;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        ecc_code_e        code;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic             addr_ok;
    logic [CNT_W:0]   cnt_sum;
    logic [CNT_W-1:0] cnt_upd;
    ecc_code_e        end_code;

    ecc_addr_check #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BYTES(ALIGN_BYTES),
        .ADDR_LIMIT (ADDR_LIMIT)
    ) u_addr_check (
        .addr_i(start_addr_i),
        .ok_o  (addr_ok)
    );

    // Saturating byte count including a beat that arrives this cycle.
    always_comb begin
        cnt_sum = {1'b0, st_q.cnt} + STEP;
        if (!beat_i) begin
            cnt_upd = st_q.cnt;
        end else if (cnt_sum[CNT_W]) begin
            cnt_upd = '1;
        end else begin
            cnt_upd = cnt_sum[CNT_W-1:0];
        end
    end

    ecc_outcome_classify #(
        .LEN_W     (LEN_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_classify (
        .no_skip_i   (!st_q.skip),
        .got_bytes_i (cnt_upd),
        .want_bytes_i(st_q.len),
        .code_o      (end_code)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                if (addr_ok) begin
                    st_d.busy = 1'b1;
                    st_d.skip = skip_mode_i;
                    st_d.len  = start_len_i;
                    st_d.cnt  = '0;
                end else begin
                    st_d.code = ST_ADDR_FAULT;
                end
            end
        end else begin
            st_d.cnt = cnt_upd;
            if (end_i) begin
                // Code and busy change on the same edge: no stale window.
                st_d.busy = 1'b0;
                st_d.code = end_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, skip: 1'b0, len: '0, cnt: '0, code: ST_PASS};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o        = st_q.busy;
    assign last_status_o = st_q.code;
endmodule

// File: rtl/ecc_op_tracker_chk.sv
module ecc_op_tracker_chk #(
    parameter int          ADDR_W      = 32,
    parameter int          ALIGN_BYTES = 512,
    parameter int unsigned ADDR_LIMIT  = 32'h0100_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              end_i,
    input logic              busy_o,
    input logic [1:0]        last_status_o
);
    logic addr_good;
    assign addr_good = ((start_addr_i % ADDR_W'(ALIGN_BYTES)) == '0)
                    && (start_addr_i < ADDR_W'(ADDR_LIMIT));

    // R2
    good_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && addr_good) |=> busy_o);

    // R3
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !addr_good) |=> (!busy_o && last_status_o == 2'b01));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !end_i) |=> busy_o);

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && end_i) |=> !busy_o);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_o && !end_i) || (!busy_o && !start_i)) |=> $stable(last_status_o));
endmodule

bind ecc_op_tracker ecc_op_tracker_chk #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BYTES(ALIGN_BYTES),
    .ADDR_LIMIT (ADDR_LIMIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .end_i        (end_i),
    .busy_o       (busy_o),
    .last_status_o(last_status_o)
);

// File: tb/ecc_op_tracker_tb.sv
module ecc_op_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [LEN_W-1:0]  start_len_i = '0;
    logic              skip_mode_i = 1'b0;
    logic              beat_i = 1'b0;
    logic              end_i = 1'b0;
    logic              busy_o;
    logic [1:0]        last_status_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_op_tracker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .start_len_i  (start_len_i),
        .skip_mode_i  (skip_mode_i),
        .beat_i       (beat_i),
        .end_i        (end_i),
        .busy_o       (busy_o),
        .last_status_o(last_status_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Start, supply nbeats beats, end, check outcome in the first idle cycle.
    task automatic run_op(input string req, input logic [ADDR_W-1:0] addr,
                          input int len, input logic skip, input int nbeats,
                          input bit end_on_last, input int exp_code);
        int prev_code;
        prev_code    = int'(last_status_o);
        start_i      = 1'b1;
        start_addr_i = addr;
        start_len_i  = LEN_W'(len);
        skip_mode_i  = skip;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R2 busy after start"}, int'(busy_o), 1);
        check({req, " R9 code held at start"}, int'(last_status_o), prev_code);
        for (int i = 0; i < nbeats; i++) begin
            beat_i = 1'b1;
            end_i  = (end_on_last && i == nbeats - 1);
            @(negedge clk);
        end
        beat_i = 1'b0;
        if (!end_on_last || nbeats == 0) begin
            check({req, " R9 code held while busy"}, int'(last_status_o), prev_code);
            end_i = 1'b1;
            @(negedge clk);
        end
        end_i = 1'b0;
        check({req, " R7 busy low after end"}, int'(busy_o), 0);
        check({req, " outcome in first idle cycle"}, int'(last_status_o), exp_code);
    endtask

    task automatic t_reset();
        check("R1 busy at reset", int'(busy_o), 0);
        check("R1 code at reset", int'(last_status_o), 0);
    endtask

    task automatic t_full_page_pass();
        run_op("R6 full page", 32'h0000_0800, 2048, 1'b0, 512, 1'b0, 0);
    endtask

    task automatic t_beat_with_end();
        run_op("R10 beat on end", 32'h0000_0200, 256, 1'b1, 64, 1'b1, 0);
    endtask

    task automatic t_short_page();
        run_op("R4 short page", 32'h0000_0000, 256, 1'b0, 64, 1'b0, 3);
    endtask

    task automatic t_priority();
        run_op("R4 priority over R5", 32'h0000_0400, 2048, 1'b0, 100, 1'b0, 3);
    endtask

    task automatic t_len_mismatch();
        run_op("R5 skip mismatch", 32'h0000_0600, 512, 1'b1, 100, 1'b0, 2);
        run_op("R5 over page", 32'h0000_0000, 1024, 1'b0, 512, 1'b0, 2);
    endtask

    task automatic t_bad_addr(input string req, input logic [ADDR_W-1:0] addr);
        start_i      = 1'b1;
        start_addr_i = addr;
        start_len_i  = 16'd512;
        skip_mode_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R3 busy stays low"}, int'(busy_o), 0);
        check({req, " R3 code"}, int'(last_status_o), 1);
        for (int i = 0; i < 4; i++) begin
            beat_i = 1'b1;
            end_i  = (i == 3);
            @(negedge clk);
        end
        beat_i = 1'b0;
        end_i  = 1'b0;
        @(negedge clk);
        check({req, " R3 idle beats ignored, busy"}, int'(busy_o), 0);
        check({req, " R3 idle end ignored, code"}, int'(last_status_o), 1);
    endtask

    task automatic t_stale_after_abort();
        run_op("R5 abort before", 32'h0000_0000, 512, 1'b1, 10, 1'b0, 2);
        run_op("R7 pass after abort", 32'h0000_0200, 512, 1'b1, 128, 1'b0, 0);
    endtask

    task automatic t_start_while_busy();
        start_i      = 1'b1;
        start_addr_i = 32'h0000_0000;
        start_len_i  = 16'd64;
        skip_mode_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy after first start", int'(busy_o), 1);
        for (int i = 0; i < 8; i++) begin
            beat_i = 1'b1;
            @(negedge clk);
        end
        start_i      = 1'b1;
        start_addr_i = 32'h0000_0004;
        start_len_i  = 16'd4;
        skip_mode_i  = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy kept on second start", int'(busy_o), 1);
        check("R9 code held while busy", int'(last_status_o), 1);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
        end
        beat_i = 1'b0;
        end_i  = 1'b1;
        @(negedge clk);
        end_i = 1'b0;
        check("R8 busy low after end", int'(busy_o), 0);
        check("R8 first operation outcome kept", int'(last_status_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_page_pass();
        t_beat_with_end();
        t_short_page();
        t_priority();
        t_len_mismatch();
        t_bad_addr("misaligned", 32'h0000_0100);
        t_stale_after_abort();
        t_bad_addr("out of range", 32'h0100_0000);
        t_start_while_busy();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule